// File: doc/BRIEF.md
# Host Register Port with CAM Access Arbiter

This block sits between a host processor and a content-addressable memory (CAM) used for station-address filtering. The host reaches a small set of internal registers (filter control, status, learn/update/purge op-codes, time stamp, associated data) over a synchronous strobed bus with a READY handshake. Four addresses turn a host access into a single CAM bus cycle, whose kind (instruction/config versus data, write versus read, chain enable low versus high) is chosen by the address bits and the write-enable level.

The network compare engine shares the CAM through a request/grant pair. The network always has priority: a host CAM access that arrives while the network owns the CAM is held pending, with READY kept low until the network has let go and the host cycle itself has finished. Once a host CAM cycle is launched it runs to completion before the network is granted. Internal register accesses never touch the CAM and are never delayed.

All timing is counted in system-clock cycles. An access starts on the first rising edge at which chip select and address strobe are both low, and the address is captured on that edge.

Top module: `host_cam_port`

## Requirements
- R1: After reset, READY is high, the host bus output enable is low, all CAM strobes are high with the CAM bus undriven, and the learn, update and purge op-code registers read 0334h, 0300h and 043Dh.
- R2: A write to register 0 (control), 2 (learn op-code), 8 (update op-code) or 9 (purge op-code) drops READY for exactly one cycle after the start edge, and the value on the data bus at the second edge is stored.
- R3: A read of an internal register keeps READY high and presents the data with output enable high after the start edge; address 1 returns the 8-bit status input zero-extended, address 3 returns the associated-data input, and addresses B to F return 0000h.
- R4: Writes to addresses 1, 3 and B to F change no register.
- R5: A host CAM write (addresses 4 to 7, write enable low) with the CAM free keeps READY low for exactly 3 cycles, pulses the CAM enable low for one cycle, drives the CAM data bus with the host data, holds write low, sets command/data select high only when address bit 1 is 1, and sets chain enable high only when address bit 0 is 1.
- R6: A host CAM read with the CAM free keeps READY low for exactly 5 cycles, never drives the CAM data bus, and then returns the CAM data-bus value on the host bus with output enable high.
- R7: While the network holds the grant, the CAM pins follow the network's strobes and data; a host CAM access started then waits, so a write begun two cycles into a grant that is released four cycles later holds READY low for 8 cycles.
- R8: A network request raised during a host CAM cycle is not granted until the cycle after that host cycle ends.
- R9: A write to address A stores the time stamp (low byte old stamp, high byte new stamp) and produces a one-cycle purge-start pulse in the cycle after the second edge.
- R10: The host bus output enable drops on the first edge at which chip select is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_as_n | input | 1 | Host address strobe, active low |
| host_addr | input | 4 | Host register address |
| host_we_n | input | 1 | Host write enable, low = write |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data |
| host_rdata_oe | output | 1 | Host data bus drive enable |
| host_ready | output | 1 | Access complete when high |
| stat_in | input | 8 | Status bits from the filter logic |
| assoc_in | input | 16 | Associated data from the filter logic |
| ctrl_q | output | 16 | Filter control register |
| learn_op_q | output | 16 | Learn op-code register |
| update_op_q | output | 16 | Update op-code register |
| purge_op_q | output | 16 | Purge op-code register |
| stamp_q | output | 16 | Time stamp register (high new, low old) |
| purge_go | output | 1 | One-cycle purge start pulse |
| net_req | input | 1 | Network requests the CAM |
| net_gnt | output | 1 | Network owns the CAM |
| net_e_n | input | 1 | Network CAM enable |
| net_cm_n | input | 1 | Network command/data select |
| net_w_n | input | 1 | Network CAM write |
| net_ec_n | input | 1 | Network chain enable |
| net_dq | input | 16 | Network CAM write data |
| net_dq_oe | input | 1 | Network CAM data drive enable |
| cam_e_n | output | 1 | CAM enable strobe |
| cam_cm_n | output | 1 | CAM command (low) / data (high) select |
| cam_w_n | output | 1 | CAM write (low) / read (high) |
| cam_ec_n | output | 1 | CAM daisy-chain enable |
| cam_dq_out | output | 16 | CAM data bus out |
| cam_dq_oe | output | 1 | CAM data bus drive enable |
| cam_dq_in | input | 16 | CAM data bus in |

## Verification
The bench targets the READY cycle counts of each access kind, since a sequencer off by one edge would release the host early and let it sample stale CAM data or reissue an access mid-cycle. It drives a host CAM write into an active network grant and counts the stretched READY, which a design that let the host win or lost the pending request would shorten or hang. It raises a network request mid-way through a host CAM read to catch a grant handed out while the host still holds the strobes, and it writes reserved addresses and reads the unmapped range to catch decoders that alias them onto real registers.

// File: rtl/hcp_pkg.sv
package hcp_pkg;
  localparam int unsigned REG_AW = 4;

  localparam logic [REG_AW-1:0] ADR_CTRL   = 4'h0;
  localparam logic [REG_AW-1:0] ADR_STAT   = 4'h1;
  localparam logic [REG_AW-1:0] ADR_LEARN  = 4'h2;
  localparam logic [REG_AW-1:0] ADR_ASSOC  = 4'h3;
  localparam logic [REG_AW-1:0] ADR_UPDATE = 4'h8;
  localparam logic [REG_AW-1:0] ADR_PURGE  = 4'h9;
  localparam logic [REG_AW-1:0] ADR_STAMP  = 4'hA;

  localparam logic [15:0] RST_CTRL   = 16'h0000;
  localparam logic [15:0] RST_LEARN  = 16'h0334;
  localparam logic [15:0] RST_UPDATE = 16'h0300;
  localparam logic [15:0] RST_PURGE  = 16'h043D;
  localparam logic [15:0] RST_STAMP  = 16'h0000;

  // CAM window: addresses 4..7
  function automatic logic is_cam_addr(input logic [REG_AW-1:0] a);
    return (a[REG_AW-1:2] == 2'b01);
  endfunction
endpackage

// File: rtl/hcp_regfile.sv
module hcp_regfile import hcp_pkg::*; #(
  parameter int DW  = 16,
  parameter int AW  = 4,
  parameter int STW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  input  logic [STW-1:0] stat_in,
  input  logic [DW-1:0] assoc_in,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] learn_q,
  output logic [DW-1:0] update_q,
  output logic [DW-1:0] purge_q,
  output logic [DW-1:0] stamp_q,
  output logic          purge_go
);
  localparam int PADW = DW - STW;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= DW'(RST_CTRL);
      learn_q  <= DW'(RST_LEARN);
      update_q <= DW'(RST_UPDATE);
      purge_q  <= DW'(RST_PURGE);
      stamp_q  <= DW'(RST_STAMP);
      purge_go <= 1'b0;
    end else begin
      purge_go <= 1'b0;
      if (wr_en) begin
        unique case (wr_addr)
          ADR_CTRL:   ctrl_q   <= wr_data;
          ADR_LEARN:  learn_q  <= wr_data;
          ADR_UPDATE: update_q <= wr_data;
          ADR_PURGE:  purge_q  <= wr_data;
          ADR_STAMP: begin
            stamp_q  <= wr_data;
            purge_go <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (rd_addr)
      ADR_CTRL:   rd_data = ctrl_q;
      ADR_STAT:   rd_data = {{PADW{1'b0}}, stat_in};
      ADR_LEARN:  rd_data = learn_q;
      ADR_ASSOC:  rd_data = assoc_in;
      ADR_UPDATE: rd_data = update_q;
      ADR_PURGE:  rd_data = purge_q;
      ADR_STAMP:  rd_data = stamp_q;
      default:    rd_data = '0;
    endcase
  end

  // R9: the purge start is a single-cycle pulse
  assert_purge_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    purge_go |=> !purge_go);
endmodule

// File: rtl/hcp_cam_seq.sv
module hcp_cam_seq #(
  parameter int DW     = 16,
  parameter int WR_CYC = 3,
  parameter int RD_CYC = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [1:0]    req_sel,
  input  logic          req_we_n,
  input  logic [DW-1:0] req_wdata,
  input  logic          net_req,
  output logic          net_gnt,
  input  logic          net_e_n,
  input  logic          net_cm_n,
  input  logic          net_w_n,
  input  logic          net_ec_n,
  input  logic [DW-1:0] net_dq,
  input  logic          net_dq_oe,
  output logic          cam_e_n,
  output logic          cam_cm_n,
  output logic          cam_w_n,
  output logic          cam_ec_n,
  output logic [DW-1:0] cam_dq_out,
  output logic          cam_dq_oe,
  output logic          busy,
  output logic          done,
  output logic          done_rd
);
  localparam int MAXC = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic          pend, act, act_rd;
  logic [CW-1:0] cnt;
  logic [1:0]    p_sel;
  logic          p_we_n;
  logic [DW-1:0] p_wdata;

  logic          hreq, launch;
  logic [1:0]    s_sel;
  logic          s_we_n;
  logic [DW-1:0] s_wdata;

  assign hreq    = req || pend;
  assign launch  = hreq && !net_req && !net_gnt && !act;
  assign s_sel   = pend ? p_sel   : req_sel;
  assign s_we_n  = pend ? p_we_n  : req_we_n;
  assign s_wdata = pend ? p_wdata : req_wdata;

  assign done    = act && (cnt == (act_rd ? CW'(RD_CYC) : CW'(WR_CYC)));
  assign done_rd = done && act_rd;
  assign busy    = pend || act;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= 1'b0;
      act     <= 1'b0;
      act_rd  <= 1'b0;
      cnt     <= '0;
      p_sel   <= '0;
      p_we_n  <= 1'b1;
      p_wdata <= '0;
      net_gnt <= 1'b0;
    end else begin
      net_gnt <= net_req && !act;
      if (req) begin
        p_sel   <= req_sel;
        p_we_n  <= req_we_n;
        p_wdata <= req_wdata;
      end
      if (launch)   pend <= 1'b0;
      else if (req) pend <= 1'b1;
      if (launch) begin
        act    <= 1'b1;
        act_rd <= s_we_n;
        cnt    <= CW'(1);
      end else if (act) begin
        if (done) act <= 1'b0;
        else      cnt <= cnt + CW'(1);
      end
    end
  end

  // CAM pins, registered
  always_ff @(posedge clk) begin
    if (rst) begin
      cam_e_n    <= 1'b1;
      cam_cm_n   <= 1'b1;
      cam_w_n    <= 1'b1;
      cam_ec_n   <= 1'b1;
      cam_dq_out <= '0;
      cam_dq_oe  <= 1'b0;
    end else if (launch) begin
      cam_e_n    <= 1'b0;
      cam_cm_n   <= s_sel[1];
      cam_ec_n   <= s_sel[0];
      cam_w_n    <= s_we_n;
      cam_dq_out <= s_wdata;
      cam_dq_oe  <= !s_we_n;
    end else if (act) begin
      cam_e_n <= 1'b1;
      if (done) begin
        cam_cm_n  <= 1'b1;
        cam_w_n   <= 1'b1;
        cam_ec_n  <= 1'b1;
        cam_dq_oe <= 1'b0;
      end
    end else if (net_gnt) begin
      cam_e_n    <= net_e_n;
      cam_cm_n   <= net_cm_n;
      cam_w_n    <= net_w_n;
      cam_ec_n   <= net_ec_n;
      cam_dq_out <= net_dq;
      cam_dq_oe  <= net_dq_oe;
    end else begin
      cam_e_n   <= 1'b1;
      cam_cm_n  <= 1'b1;
      cam_w_n   <= 1'b1;
      cam_ec_n  <= 1'b1;
      cam_dq_oe <= 1'b0;
    end
  end

  // R7/R8: host cycle and network grant never overlap
  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (rst)
    !(net_gnt && act));
  // R7: a host cycle is never launched while the network holds the CAM
  assert_net_first_R7: assert property (@(posedge clk) disable iff (rst)
    (net_gnt && net_req) |=> !act);
  // R6: sequencer count stays inside the longest cycle
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
    act |-> (cnt <= CW'(MAXC)));
  // R5: a host cycle drives the CAM bus only when writing
  assert_dq_write_R5: assert property (@(posedge clk) disable iff (rst)
    (act && act_rd) |-> !cam_dq_oe);
endmodule

// File: rtl/host_cam_port.sv
module host_cam_port import hcp_pkg::*; #(
  parameter int DW         = 16,
  parameter int AW         = 4,
  parameter int STW        = 8,
  parameter int CAM_WR_CYC = 3,
  parameter int CAM_RD_CYC = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           host_cs_n,
  input  logic           host_as_n,
  input  logic [AW-1:0]  host_addr,
  input  logic           host_we_n,
  input  logic [DW-1:0]  host_wdata,
  output logic [DW-1:0]  host_rdata,
  output logic           host_rdata_oe,
  output logic           host_ready,
  input  logic [STW-1:0] stat_in,
  input  logic [DW-1:0]  assoc_in,
  output logic [DW-1:0]  ctrl_q,
  output logic [DW-1:0]  learn_op_q,
  output logic [DW-1:0]  update_op_q,
  output logic [DW-1:0]  purge_op_q,
  output logic [DW-1:0]  stamp_q,
  output logic           purge_go,
  input  logic           net_req,
  output logic           net_gnt,
  input  logic           net_e_n,
  input  logic           net_cm_n,
  input  logic           net_w_n,
  input  logic           net_ec_n,
  input  logic [DW-1:0]  net_dq,
  input  logic           net_dq_oe,
  output logic           cam_e_n,
  output logic           cam_cm_n,
  output logic           cam_w_n,
  output logic           cam_ec_n,
  output logic [DW-1:0]  cam_dq_out,
  output logic           cam_dq_oe,
  input  logic [DW-1:0]  cam_dq_in
);
  logic          armed, wr_q;
  logic [AW-1:0] lat_addr;
  logic          start, is_cam, cam_req, reg_rd_start;
  logic          cam_busy, cam_done, cam_done_rd;
  logic [DW-1:0] reg_rd;

  assign is_cam       = is_cam_addr(host_addr);
  assign start        = !host_cs_n && !host_as_n && armed && !wr_q && !cam_busy;
  assign cam_req      = start && is_cam;
  assign reg_rd_start = start && host_we_n && !is_cam;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed         <= 1'b1;
      wr_q          <= 1'b0;
      lat_addr      <= '0;
      host_ready    <= 1'b1;
      host_rdata    <= '0;
      host_rdata_oe <= 1'b0;
    end else begin
      if (host_cs_n || host_as_n) armed <= 1'b1;
      else if (start)             armed <= 1'b0;
      if (start) lat_addr <= host_addr;
      wr_q <= start && !host_we_n && !is_cam;
      if (start && (!host_we_n || is_cam)) host_ready <= 1'b0;
      else if (wr_q || cam_done)           host_ready <= 1'b1;
      if (reg_rd_start)     host_rdata <= reg_rd;
      else if (cam_done_rd) host_rdata <= cam_dq_in;
      host_rdata_oe <= !host_cs_n && (host_rdata_oe || reg_rd_start || cam_done_rd);
    end
  end

  hcp_regfile #(.DW(DW), .AW(AW), .STW(STW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_q),
    .wr_addr  (lat_addr),
    .wr_data  (host_wdata),
    .rd_addr  (host_addr),
    .stat_in  (stat_in),
    .assoc_in (assoc_in),
    .rd_data  (reg_rd),
    .ctrl_q   (ctrl_q),
    .learn_q  (learn_op_q),
    .update_q (update_op_q),
    .purge_q  (purge_op_q),
    .stamp_q  (stamp_q),
    .purge_go (purge_go)
  );

  hcp_cam_seq #(.DW(DW), .WR_CYC(CAM_WR_CYC), .RD_CYC(CAM_RD_CYC)) u_cam (
    .clk        (clk),
    .rst        (rst),
    .req        (cam_req),
    .req_sel    (host_addr[1:0]),
    .req_we_n   (host_we_n),
    .req_wdata  (host_wdata),
    .net_req    (net_req),
    .net_gnt    (net_gnt),
    .net_e_n    (net_e_n),
    .net_cm_n   (net_cm_n),
    .net_w_n    (net_w_n),
    .net_ec_n   (net_ec_n),
    .net_dq     (net_dq),
    .net_dq_oe  (net_dq_oe),
    .cam_e_n    (cam_e_n),
    .cam_cm_n   (cam_cm_n),
    .cam_w_n    (cam_w_n),
    .cam_ec_n   (cam_ec_n),
    .cam_dq_out (cam_dq_out),
    .cam_dq_oe  (cam_dq_oe),
    .busy       (cam_busy),
    .done       (cam_done),
    .done_rd    (cam_done_rd)
  );

  // R2: an internal register write releases READY on the following edge
  assert_reg_write_ready_R2: assert property (@(posedge clk) disable iff (rst)
    wr_q |=> host_ready);
  // R10: the host bus is only driven after chip select was seen low
  assert_oe_cs_R10: assert property (@(posedge clk) disable iff (rst)
    host_rdata_oe |-> !$past(host_cs_n));
  // R3: an internal read never drops READY
  assert_read_ready_R3: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_start && host_ready) |=> host_ready);
endmodule

// File: tb/sim_host_cam_port.sv
`timescale 1ns/1ps
module sim_host_cam_port;
  logic        clk = 1'b0;
  logic        rst;
  logic        host_cs_n, host_as_n, host_we_n;
  logic [3:0]  host_addr;
  logic [15:0] host_wdata;
  logic [15:0] host_rdata;
  logic        host_rdata_oe, host_ready;
  logic [7:0]  stat_in;
  logic [15:0] assoc_in;
  logic [15:0] ctrl_q, learn_op_q, update_op_q, purge_op_q, stamp_q;
  logic        purge_go;
  logic        net_req, net_gnt, net_e_n, net_cm_n, net_w_n, net_ec_n, net_dq_oe;
  logic [15:0] net_dq;
  logic        cam_e_n, cam_cm_n, cam_w_n, cam_ec_n, cam_dq_oe;
  logic [15:0] cam_dq_out, cam_dq_in;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  host_cam_port u0 (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic release_bus();
    host_cs_n = 1'b1; host_as_n = 1'b1; host_we_n = 1'b1;
  endtask

  task automatic reg_write(input string req, input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_we_n = 1'b0; host_cs_n = 1'b0; host_as_n = 1'b0;
    @(negedge clk);
    chk({req, " ready low"}, 32'(host_ready), 32'd0);
    @(negedge clk);
    chk({req, " ready back"}, 32'(host_ready), 32'd1);
    release_bus();
    @(negedge clk);
  endtask

  task automatic reg_read(input string req, input logic [3:0] a, input logic [15:0] e);
    @(negedge clk);
    host_addr = a; host_we_n = 1'b1; host_cs_n = 1'b0; host_as_n = 1'b0;
    @(negedge clk);
    chk({req, " ready high"}, 32'(host_ready), 32'd1);
    chk({req, " oe"}, 32'(host_rdata_oe), 32'd1);
    chk({req, " data"}, 32'(host_rdata), 32'(e));
    release_bus();
    @(negedge clk);
    chk("R10 oe drop", 32'(host_rdata_oe), 32'd0);
  endtask

  // columns: write flag, address, data, expected read value
  localparam logic [36:0] VEC [0:11] = '{
    {1'b1, 4'h0, 16'h1234, 16'h0000},
    {1'b0, 4'h0, 16'h0000, 16'h1234},
    {1'b1, 4'h2, 16'hABCD, 16'h0000},
    {1'b0, 4'h2, 16'h0000, 16'hABCD},
    {1'b1, 4'h8, 16'h0328, 16'h0000},
    {1'b0, 4'h8, 16'h0000, 16'h0328},
    {1'b1, 4'h9, 16'h5A5A, 16'h0000},
    {1'b0, 4'h9, 16'h0000, 16'h5A5A},
    {1'b0, 4'h1, 16'h0000, 16'h00C3},
    {1'b0, 4'h3, 16'h0000, 16'hBEEF},
    {1'b0, 4'hB, 16'h0000, 16'h0000},
    {1'b0, 4'hF, 16'h0000, 16'h0000}
  };

  initial begin
    #(4 * 20000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int lows;
    rst = 1'b1; release_bus(); host_addr = '0; host_wdata = '0;
    stat_in = 8'hC3; assoc_in = 16'hBEEF; cam_dq_in = 16'h7E57;
    net_req = 0; net_e_n = 1; net_cm_n = 1; net_w_n = 1; net_ec_n = 1;
    net_dq = 16'h0; net_dq_oe = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 ready", 32'(host_ready), 32'd1);
    chk("R1 oe", 32'(host_rdata_oe), 32'd0);
    chk("R1 cam strobes", 32'({cam_e_n, cam_cm_n, cam_w_n, cam_ec_n, cam_dq_oe}), 32'b11110);
    chk("R1 learn", 32'(learn_op_q), 32'h0334);
    chk("R1 update", 32'(update_op_q), 32'h0300);
    chk("R1 purge", 32'(purge_op_q), 32'h043D);
    reg_read("R1 learn read", 4'h2, 16'h0334);

    // R2/R3 vector walk
    for (int i = 0; i < 12; i++) begin
      if (VEC[i][36]) reg_write("R2 vec write", VEC[i][35:32], VEC[i][31:16]);
      else            reg_read("R3 vec read", VEC[i][35:32], VEC[i][15:0]);
    end
    chk("R2 ctrl port", 32'(ctrl_q), 32'h1234);

    // R4 ignored writes
    reg_write("R4 wr 1", 4'h1, 16'hFFFF);
    reg_write("R4 wr 3", 4'h3, 16'hFFFF);
    reg_write("R4 wr C", 4'hC, 16'hFFFF);
    chk("R4 ctrl", 32'(ctrl_q), 32'h1234);
    chk("R4 learn", 32'(learn_op_q), 32'hABCD);
    chk("R4 stamp", 32'(stamp_q), 32'h0000);
    reg_read("R4 status", 4'h1, 16'h00C3);

    // R9 time stamp write and purge pulse
    @(negedge clk);
    host_addr = 4'hA; host_wdata = 16'h1A05; host_we_n = 0; host_cs_n = 0; host_as_n = 0;
    @(negedge clk);
    chk("R9 no pulse yet", 32'(purge_go), 32'd0);
    @(negedge clk);
    chk("R9 pulse", 32'(purge_go), 32'd1);
    chk("R9 old stamp", 32'(stamp_q[7:0]), 32'h05);
    chk("R9 new stamp", 32'(stamp_q[15:8]), 32'h1A);
    release_bus();
    @(negedge clk);
    chk("R9 pulse end", 32'(purge_go), 32'd0);

    // R5 CAM command write, chain enable high (addr 5)
    @(negedge clk);
    host_addr = 4'h5; host_wdata = 16'h0228; host_we_n = 0; host_cs_n = 0; host_as_n = 0;
    @(negedge clk);
    chk("R5 strobes", 32'({cam_e_n, cam_cm_n, cam_w_n, cam_ec_n, cam_dq_oe}), 32'b00011);
    chk("R5 dq", 32'(cam_dq_out), 32'h0228);
    lows = 1;
    @(negedge clk);
    chk("R5 e pulse", 32'(cam_e_n), 32'd1);
    while (host_ready == 0 && lows < 20) begin lows++; @(negedge clk); end
    chk("R5 ready lows", 32'(lows), 32'd3);
    release_bus();
    @(negedge clk);

    // R5 CAM data write, chain enable low (addr 6)
    @(negedge clk);
    host_addr = 4'h6; host_wdata = 16'h55AA; host_we_n = 0; host_cs_n = 0; host_as_n = 0;
    @(negedge clk);
    chk("R5 data strobes", 32'({cam_e_n, cam_cm_n, cam_w_n, cam_ec_n, cam_dq_oe}), 32'b01001);
    lows = 0;
    while (host_ready == 0 && lows < 20) begin lows++; @(negedge clk); end
    chk("R5 data lows", 32'(lows), 32'd3);
    release_bus();
    @(negedge clk);

    // R6 + R8: CAM data read (addr 7), network asks mid-cycle
    @(negedge clk);
    host_addr = 4'h7; host_we_n = 1; host_cs_n = 0; host_as_n = 0;
    @(negedge clk);
    chk("R6 strobes", 32'({cam_e_n, cam_cm_n, cam_w_n, cam_ec_n, cam_dq_oe}), 32'b01110);
    net_req = 1;
    lows = 0;
    for (int k = 1; k <= 5; k++) begin
      if (host_ready == 0) lows++;
      if (k >= 2) chk("R8 no grant during host", 32'(net_gnt), 32'd0);
      @(negedge clk);
    end
    chk("R6 ready lows", 32'(lows), 32'd5);
    chk("R6 ready back", 32'(host_ready), 32'd1);
    chk("R6 data", 32'(host_rdata), 32'h7E57);
    chk("R6 oe", 32'(host_rdata_oe), 32'd1);
    chk("R8 grant held off", 32'(net_gnt), 32'd0);
    release_bus();
    @(negedge clk);
    chk("R8 grant after", 32'(net_gnt), 32'd1);

    // R7 network owns the CAM, host write waits
    net_e_n = 0; net_cm_n = 0; net_w_n = 0; net_ec_n = 0; net_dq = 16'hC0DE; net_dq_oe = 1;
    @(negedge clk);
    chk("R7 net pins", 32'({cam_e_n, cam_cm_n, cam_w_n, cam_ec_n, cam_dq_oe}), 32'b00001);
    chk("R7 net dq", 32'(cam_dq_out), 32'hC0DE);
    host_addr = 4'h4; host_wdata = 16'h1111; host_we_n = 0; host_cs_n = 0; host_as_n = 0;
    lows = 0;
    for (int k = 1; k <= 30; k++) begin
      @(negedge clk);
      if (host_ready == 1) break;
      lows++;
      if (k == 4) begin
        net_req = 0; net_e_n = 1; net_cm_n = 1; net_w_n = 1; net_ec_n = 1; net_dq_oe = 0;
      end
    end
    chk("R7 stretched lows", 32'(lows), 32'd8);
    release_bus();
    @(negedge clk);
    chk("R7 idle after", 32'({cam_e_n, cam_dq_oe, net_gnt}), 32'b100);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule